// File: doc/BRIEF.md
# Whole-Cell FIFO with Cell Counter

This block buffers fixed-length ATM cells for a single PHY between a writer and a reader. Words go into a RAM one at a time. A cell becomes visible to the reader only after all of its words are stored and the writer pulses a commit input. The reader pulls a cell word by word and then pulses a release input, which frees the cell's slot. Whole cells are counted on both sides. The read side raises a cell-available flag for a polling master. The write side raises an almost-full flag when the FIFO has no room for one more complete cell.

The writer marks the first word of each cell with a start-of-cell strobe. If that strobe arrives before the cell in progress is complete, the partial cell is dropped. The write position goes back to the start of the current slot, and the strobed word becomes word 0 of a new cell. The two sides may share one clock, or they may run on unrelated clocks. The `ASYNC` parameter selects the mode. When the clocks are unrelated, only cell-granular pointers cross between the two domains, as Gray codes through two-flop synchronizers. Cell length is 52 or 54 bytes, the bus is 8 or 16 bits wide, and the capacity is 9 cells by default.

Top module: `cell_fifo`

## Requirements
- R1: During reset and in the first cycle after it, `rd_empty` is 1, `rd_avail` is 0 and `wr_afull` is 0.
- R2: A cell becomes readable only after `CELL_WORDS` words (CELL_BYTES divided by DATA_W/8) have been written and `wr_inc` is high on or after the last word. Before that commit, `rd_avail` stays 0 no matter how many words were written.
- R3: A `wr_inc` pulse is ignored while the cell in progress holds fewer than `CELL_WORDS` words.
- R4: Words leave in the order they were written. `rd_data` holds the word one `rd_clk` cycle after the `rd_en` that fetched it. In 16-bit mode the earlier byte of a pair travels in bits 15:8 and the later byte in bits 7:0, unchanged.
- R5: A write with `wr_soc` high while a cell is partly written discards that partial cell. The strobed word becomes word 0 of a new cell, and the discarded words are never read.
- R6: `rd_avail` is 1 exactly when at least one committed cell is unreleased, and `rd_empty` is always its inverse. A `rd_dec` pulse releases the cell being read, and releasing the last cell returns `rd_empty` to 1.
- R7: `wr_afull` rises once `CELLS` cells are committed and unreleased. It falls after a release has crossed to the write side.
- R8: While `wr_afull` is 1, writes and `wr_inc` are ignored. The stored cells and the count stay unchanged.
- R9: While `rd_empty` is 1, `rd_en` and `rd_dec` are ignored. The next committed cell is then read from its word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_en | input | 1 | Store `wr_data` this cycle |
| wr_soc | input | 1 | Marks the word as the first of a cell |
| wr_inc | input | 1 | Commit the completed cell |
| wr_data | input | DATA_W | Write word |
| wr_afull | output | 1 | No room for another whole cell |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_en | input | 1 | Fetch the next word of the current cell |
| rd_dec | input | 1 | Release the current cell |
| rd_data | output | DATA_W | Read word, valid one cycle after `rd_en` |
| rd_empty | output | 1 | No committed cell is waiting |
| rd_avail | output | 1 | At least one committed cell is waiting |

## Verification
The main path is tried with four traffic shapes:
- a clean cell written and read back in isolation;
- a cell preceded by an abandoned partial cell;
- nine cells filling the store, followed by a refused tenth;
- a write of one cell overlapping the read of another.

The scoreboard tells ordering and byte-lane errors apart from discard errors, because the abandoned words carry a distinct cell number and must never appear at `rd_data`. Flag checks after a premature commit, after reads and releases on an empty FIFO, and at the full boundary separate the cell counter's decisions from the word datapath.

// File: rtl/cell_fifo_pkg.sv
package cell_fifo_pkg;

    typedef enum logic {
        XFER_SAME_CLK = 1'b0,
        XFER_GRAY_2FF = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic en;
        logic soc;
        logic inc;
    } wr_cmd_t;

    typedef struct packed {
        logic en;
        logic dec;
    } rd_cmd_t;

    function automatic int words_per_cell(input int cell_bytes, input int data_w);
        return cell_bytes / (data_w / 8);
    endfunction

    function automatic int pow2_ceil(input int n);
        int p;
        p = 1;
        for (int i = 0; i < 31; i++) begin
            if (p < n) p = p * 2;
        end
        return p;
    endfunction

endpackage

// File: rtl/cell_fifo_ram.sv
module cell_fifo_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 864,
    parameter int AW     = 10
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/cell_fifo_xfer.sv
module cell_fifo_xfer import cell_fifo_pkg::*; #(
    parameter int         W    = 5,
    parameter xfer_mode_e MODE = XFER_GRAY_2FF
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] src_ptr,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_ptr
);
    function automatic logic [W-1:0] bin2gray(input logic [W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [W-1:0] gray2bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    generate
        if (MODE == XFER_GRAY_2FF) begin : g_gray
            logic [W-1:0] gray_src, meta_q, sync_q;
            always_ff @(posedge src_clk) begin
                if (src_rst) gray_src <= '0;
                else         gray_src <= bin2gray(src_ptr);
            end
            always_ff @(posedge dst_clk) begin
                if (dst_rst) begin
                    meta_q <= '0;
                    sync_q <= '0;
                end else begin
                    meta_q <= gray_src;
                    sync_q <= meta_q;
                end
            end
            assign dst_ptr = gray2bin(sync_q);
        end else begin : g_same
            assign dst_ptr = src_ptr;
        end
    endgenerate
endmodule

// File: rtl/cell_fifo_wr.sv
module cell_fifo_wr import cell_fifo_pkg::*; #(
    parameter int CW    = 54,
    parameter int CELLS = 9,
    parameter int PW    = 5,
    parameter int OW    = 6,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_cmd_t       cmd,
    input  logic [PW-1:0] rptr_sync,
    output logic [PW-1:0] wptr,
    output logic [OW-1:0] off,
    output logic [PW-1:0] cnt,
    output logic          afull,
    output logic          we,
    output logic [AW-1:0] waddr
);
    logic          accept, commit;
    logic [OW-1:0] eff_off, off_next;

    always_comb begin
        cnt      = wptr - rptr_sync;
        afull    = (cnt >= PW'(CELLS));
        accept   = cmd.en & ~afull;
        // an early start strobe rewinds to the slot's first word
        eff_off  = cmd.soc ? '0 : off;
        we       = accept & (eff_off < OW'(CW));
        waddr    = AW'(wptr[PW-2:0]) * AW'(CW) + AW'(eff_off);
        off_next = we ? eff_off + OW'(1) : off;
        commit   = cmd.inc & ~afull & (off_next == OW'(CW));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            off  <= '0;
        end else if (commit) begin
            wptr <= wptr + PW'(1);
            off  <= '0;
        end else begin
            off  <= off_next;
        end
    end
endmodule

// File: rtl/cell_fifo_rd.sv
module cell_fifo_rd import cell_fifo_pkg::*; #(
    parameter int CW = 54,
    parameter int PW = 5,
    parameter int OW = 6,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  rd_cmd_t       cmd,
    input  logic [PW-1:0] wptr_sync,
    output logic [PW-1:0] rptr,
    output logic          empty,
    output logic          avail,
    output logic          re,
    output logic [AW-1:0] raddr
);
    logic [OW-1:0] off;
    logic [PW-1:0] cnt;

    always_comb begin
        cnt   = wptr_sync - rptr;
        avail = (cnt >= PW'(1));
        empty = (rptr == wptr_sync);
        re    = cmd.en & ~empty & (off < OW'(CW));
        raddr = AW'(rptr[PW-2:0]) * AW'(CW) + AW'(off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr <= '0;
            off  <= '0;
        end else if (cmd.dec & ~empty) begin
            rptr <= rptr + PW'(1);
            off  <= '0;
        end else if (re) begin
            off  <= off + OW'(1);
        end
    end
endmodule

// File: rtl/cell_fifo.sv
module cell_fifo import cell_fifo_pkg::*; #(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 54,
    parameter int CELLS      = 9,
    parameter bit ASYNC      = 1'b1
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic              wr_soc,
    input  logic              wr_inc,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_afull,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic              rd_dec,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_avail
);
    localparam int CW    = words_per_cell(CELL_BYTES, DATA_W);
    localparam int SLOTS = pow2_ceil(CELLS);
    localparam int PW    = $clog2(SLOTS) + 1;
    localparam int OW    = $clog2(CW + 1);
    localparam int DEPTH = SLOTS * CW;
    localparam int AW    = $clog2(DEPTH);
    localparam xfer_mode_e MODE = ASYNC ? XFER_GRAY_2FF : XFER_SAME_CLK;

    wr_cmd_t       wcmd;
    rd_cmd_t       rcmd;
    logic [PW-1:0] wptr_c, rptr_c, wptr_rd, rptr_wr, wr_cnt;
    logic [OW-1:0] wr_off;
    logic          we, re;
    logic [AW-1:0] waddr, raddr;

    always_comb begin
        wcmd = '{en: wr_en, soc: wr_soc, inc: wr_inc};
        rcmd = '{en: rd_en, dec: rd_dec};
    end

    cell_fifo_wr #(.CW(CW), .CELLS(CELLS), .PW(PW), .OW(OW), .AW(AW)) wr_i (
        .clk(wr_clk), .rst(wr_rst), .cmd(wcmd), .rptr_sync(rptr_wr),
        .wptr(wptr_c), .off(wr_off), .cnt(wr_cnt), .afull(wr_afull),
        .we(we), .waddr(waddr)
    );

    cell_fifo_rd #(.CW(CW), .PW(PW), .OW(OW), .AW(AW)) rd_i (
        .clk(rd_clk), .rst(rd_rst), .cmd(rcmd), .wptr_sync(wptr_rd),
        .rptr(rptr_c), .empty(rd_empty), .avail(rd_avail),
        .re(re), .raddr(raddr)
    );

    cell_fifo_xfer #(.W(PW), .MODE(MODE)) w2r_i (
        .src_clk(wr_clk), .src_rst(wr_rst), .src_ptr(wptr_c),
        .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_ptr(wptr_rd)
    );

    cell_fifo_xfer #(.W(PW), .MODE(MODE)) r2w_i (
        .src_clk(rd_clk), .src_rst(rd_rst), .src_ptr(rptr_c),
        .dst_clk(wr_clk), .dst_rst(wr_rst), .dst_ptr(rptr_wr)
    );

    cell_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) ram_i (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .re(re), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: rtl/cell_fifo_chk.sv
module cell_fifo_chk #(
    parameter int PW    = 5,
    parameter int OW    = 6,
    parameter int CELLS = 9
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          wr_en,
    input logic          wr_soc,
    input logic          wr_inc,
    input logic          wr_afull,
    input logic          rd_dec,
    input logic          rd_empty,
    input logic          rd_avail,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr,
    input logic [OW-1:0] wr_off,
    input logic [PW-1:0] wr_cnt
);
    // R1
    wr_reset_chk: assert property (@(posedge wr_clk)
        wr_rst |=> (!wr_afull && wr_off == '0));

    // R1
    rd_reset_chk: assert property (@(posedge rd_clk)
        rd_rst |=> (rd_empty && !rd_avail));

    // R6
    flag_pair_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_empty != rd_avail);

    // R7
    cap_limit_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_cnt <= PW'(CELLS));

    // R2
    commit_src_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wptr != $past(wptr)) |-> $past(wr_inc));

    // R8
    full_hold_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_afull && wr_inc) |=> (wptr == $past(wptr)));

    // R5
    soc_restart_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_soc && !wr_afull && !wr_inc) |=> (wr_off == OW'(1)));

    // R9
    empty_dec_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_empty && rd_dec) |=> (rptr == $past(rptr)));
endmodule

bind cell_fifo cell_fifo_chk #(.PW(PW), .OW(OW), .CELLS(CELLS)) chk_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .wr_en(wr_en), .wr_soc(wr_soc), .wr_inc(wr_inc), .wr_afull(wr_afull),
    .rd_dec(rd_dec), .rd_empty(rd_empty), .rd_avail(rd_avail),
    .wptr(wptr_c), .rptr(rptr_c), .wr_off(wr_off), .wr_cnt(wr_cnt)
);

// File: tb/cell_fifo_tb_top.sv
module cell_fifo_tb_top;
    localparam int DW    = 16;
    localparam int CB    = 52;
    localparam int NCELL = 9;
    localparam int CW    = CB / (DW / 8);

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, wr_soc, wr_inc, rd_en, rd_dec;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          wr_afull, rd_empty, rd_avail;

    int            checks   = 0;
    int            failures = 0;
    bit            done     = 1'b0;
    bit            rd_expect = 1'b0;
    logic          rd_pend;
    logic [DW-1:0] exp_q[$];

    always #4 clk = ~clk;

    cell_fifo #(.DATA_W(DW), .CELL_BYTES(CB), .CELLS(NCELL), .ASYNC(1'b1)) dut_i (
        .wr_clk(clk), .wr_rst(rst), .wr_en(wr_en), .wr_soc(wr_soc),
        .wr_inc(wr_inc), .wr_data(wr_data), .wr_afull(wr_afull),
        .rd_clk(clk), .rd_rst(rst), .rd_en(rd_en), .rd_dec(rd_dec),
        .rd_data(rd_data), .rd_empty(rd_empty), .rd_avail(rd_avail)
    );

    function automatic logic [DW-1:0] word_of(input int c, input int w);
        logic [7:0] early, late;
        early = 8'(c * 7 + 2 * w);
        late  = 8'(c * 7 + 2 * w + 1);
        return {early, late};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_words(input int c, input int n, input int inc_at, input bit push);
        for (int w = 0; w < n; w++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_soc  = (w == 0);
            wr_inc  = (w == inc_at);
            wr_data = word_of(c, w);
            if (push) exp_q.push_back(word_of(c, w));
        end
        @(negedge clk);
        wr_en  = 1'b0;
        wr_soc = 1'b0;
        wr_inc = 1'b0;
    endtask

    task automatic write_cell(input int c, input bit push);
        write_words(c, CW, CW - 1, push);
    endtask

    task automatic read_cell();
        for (int w = 0; w < CW; w++) begin
            @(negedge clk);
            rd_expect = 1'b1;
            rd_en     = 1'b1;
            rd_dec    = (w == CW - 1);
        end
        @(negedge clk);
        rd_en  = 1'b0;
        rd_dec = 1'b0;
    endtask

    // read fetch issued at an edge yields data at the next sampling point
    always @(posedge clk) begin
        if (rst) rd_pend <= 1'b0;
        else     rd_pend <= rd_en & rd_expect;
    end

    initial begin : monitor
        logic [DW-1:0] e;
        forever begin
            @(negedge clk);
            if (rd_pend === 1'b1) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected read word", int'(rd_data), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(rd_data === e, "R4", "rd_data order/lanes", int'(rd_data), int'(e));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        rst = 1'b1;
        wr_en = 1'b0; wr_soc = 1'b0; wr_inc = 1'b0; wr_data = '0;
        rd_en = 1'b0; rd_dec = 1'b0;
        repeat (4) @(posedge clk);
        check(rd_empty === 1'b1, "R1", "rd_empty in reset", int'(rd_empty), 1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_empty === 1'b1, "R1", "rd_empty after reset", int'(rd_empty), 1);
        check(rd_avail === 1'b0, "R1", "rd_avail after reset", int'(rd_avail), 0);
        check(wr_afull === 1'b0, "R1", "wr_afull after reset", int'(wr_afull), 0);

        // R2: words without a commit stay invisible
        write_words(100, 10, -1, 1'b0);
        idle(8);
        check(rd_avail === 1'b0, "R2", "avail before commit", int'(rd_avail), 0);
        // R5: new start strobe discards the ten words above
        write_cell(1, 1'b1);
        idle(8);
        check(rd_avail === 1'b1, "R2", "avail after commit", int'(rd_avail), 1);
        check(rd_data[15:8] === 8'd0 && rd_empty === 1'b0, "R5", "no stale read", int'(rd_empty), 0);
        read_cell();
        idle(8);
        check(rd_empty === 1'b1, "R6", "empty after release", int'(rd_empty), 1);
        check(rd_avail === 1'b0, "R6", "avail after release", int'(rd_avail), 0);

        // R3: commit on word 20 of 26 is refused
        write_words(101, 20, 19, 1'b0);
        idle(8);
        check(rd_avail === 1'b0, "R3", "short commit ignored", int'(rd_avail), 0);
        write_cell(2, 1'b1);
        idle(8);
        read_cell();
        idle(8);

        // R9: reads and releases on an empty FIFO
        rd_expect = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rd_en = 1'b1; rd_dec = 1'b1;
        end
        @(negedge clk);
        rd_en = 1'b0; rd_dec = 1'b0;
        idle(4);
        check(rd_empty === 1'b1, "R9", "empty after idle reads", int'(rd_empty), 1);
        write_cell(3, 1'b1);
        idle(8);
        check(rd_avail === 1'b1, "R9", "avail after later commit", int'(rd_avail), 1);
        read_cell();
        idle(8);

        // R7/R8: fill to capacity then try one more
        for (int c = 10; c < 10 + NCELL; c++) write_cell(c, 1'b1);
        idle(8);
        check(wr_afull === 1'b1, "R7", "afull at capacity", int'(wr_afull), 1);
        write_cell(99, 1'b0);
        idle(8);
        check(wr_afull === 1'b1, "R8", "afull after refused cell", int'(wr_afull), 1);
        read_cell();
        idle(8);
        check(wr_afull === 1'b0, "R7", "afull after release", int'(wr_afull), 0);
        for (int c = 1; c < NCELL; c++) read_cell();
        idle(8);
        check(rd_empty === 1'b1, "R8", "no extra cell stored", int'(rd_empty), 1);

        // overlapped write and read
        write_cell(20, 1'b1);
        idle(8);
        fork
            write_cell(21, 1'b1);
            read_cell();
        join
        idle(8);
        check(rd_avail === 1'b1, "R6", "one cell left", int'(rd_avail), 1);
        read_cell();
        idle(8);
        check(rd_empty === 1'b1, "R6", "empty at end", int'(rd_empty), 1);
        check(exp_q.size() == 0, "R4", "all expected words read", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule